// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block decides whether the first byte after a bus START is addressed to this device. It holds three programmable address slots and a mode setting. In single mode only slot 0 takes part in the comparison. In multi mode all three slots take part. The block raises one overall match flag and a separate flag for each slot that matched. These flags stay set until the next START, so firmware can see which programmed identity was called.

The block does not receive serial data itself. A separate bit shifter supplies the assembled byte together with a one-cycle strobe when the byte is complete. A START detector supplies a one-cycle pulse for each START condition. The slots and the mode are loaded through a small write port. Only the seven upper bits of the received byte are compared. The lowest bit is the transfer direction, and it is reported on its own output when a match occurs.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While `rst_n` is low at a clock edge, all slots become 0x00 and the mode becomes single. After that edge `match_any`, `match_slot` and `rx_dir` are 0, and the block is not armed.
- R2: When `wr_en` is high, the value of `wr_sel` picks the target. Values 0, 1 and 2 load `wr_data` into that slot. Value 3 loads the mode from `wr_data[0]`, where 0 means single and 1 means multi. The new value takes part in comparisons from the next clock edge onward.
- R3: In single mode only slot 0 can match. `match_slot[1]` and `match_slot[2]` stay 0 even when the received byte equals slot 1 or slot 2.
- R4: In multi mode each of slots 0, 1 and 2 is compared, and bit i of `match_slot` stands for slot i.
- R5: A slot matches when `rx_byte[7:1]` equals `slot[7:1]`. Bit 0 of both values is ignored in the comparison. When an evaluated byte matches, `rx_dir` takes `rx_byte[0]` at that edge.
- R6: An evaluated match sets `match_any` and the matching bits of `match_slot` one cycle after the strobe edge. The flags then hold their value until the next START or reset.
- R7: If several enabled slots match the same byte, every one of their flags is set.
- R8: Only the first `addr_done` strobe after a START is evaluated. A strobe that comes before any START, or after the first strobe has already been used, changes no output.
- R9: A `start_det` pulse clears `match_any`, `match_slot` and `rx_dir`, and arms the block. If `start_det` and `addr_done` are high in the same cycle, the START takes effect and the strobe is ignored. The block stays armed for the next strobe.
- R10: A slot write in the same cycle as an evaluated strobe does not change that comparison. The comparison uses the slot value from before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable for the slots and the mode |
| wr_sel | input | 2 | Write target: 0 to 2 select a slot, 3 selects the mode |
| wr_data | input | 8 | Write data |
| start_det | input | 1 | One-cycle pulse for each START condition |
| addr_done | input | 1 | One-cycle strobe when the received byte is complete |
| rx_byte | input | 8 | Received byte: address in bits 7:1, direction in bit 0 |
| match_any | output | 1 | High when any slot matched since the last START |
| match_slot | output | 3 | Sticky match flags, one per slot |
| rx_dir | output | 1 | Direction bit of the byte that matched |

## Verification
Two pairs of events can fall in the same cycle. A START can coincide with a byte strobe, and a slot write can coincide with an evaluated strobe. The bench provokes both on purpose. In the first case it checks that the flags are cleared, that the strobe leaves no trace, and that the next strobe is still evaluated. In the second case it checks that the match follows the slot value from before the write. Every cycle is also compared against a behavioural reference model. This comparison covers stray strobes, strobes before any START, and byte patterns that differ only in the direction bit.

// File: rtl/i2c_am_pkg.sv
// Package: shared types for the I2C address matcher.
// Assumes: imported by every module of the matcher.
package i2c_am_pkg;
    typedef enum logic [0:0] {
        MODE_SINGLE = 1'b0,
        MODE_MULTI  = 1'b1
    } am_mode_e;
endpackage

// File: rtl/am_slot_regs.sv
// Module: am_slot_regs
// Holds the programmable address slots and the compare mode.
// Assumes: wr_sel values below NSLOT pick a slot, and the value NSLOT picks the mode.
module am_slot_regs
    import i2c_am_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [BYTE_W-1:0]              wr_data,
    output logic [NSLOT-1:0][BYTE_W-1:0]   slot_tbl,
    output am_mode_e                       mode
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Load one slot when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_tbl[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                slot_tbl[g] <= wr_data;
        end
    end

    // Load the mode from bit 0 when the mode is the write target.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_SINGLE;
        else if (wr_en && wr_sel == SEL_W'(NSLOT))
            mode <= am_mode_e'(wr_data[0]);
    end
endmodule

// File: rtl/am_compare.sv
// Module: am_compare
// Combinational compare of the received byte against every enabled slot.
// Assumes: bit 0 carries the direction, so only the upper bits are compared.
module am_compare
    import i2c_am_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int BYTE_W = 8
) (
    input  logic [NSLOT-1:0][BYTE_W-1:0]   slot_tbl,
    input  am_mode_e                       mode,
    input  logic [BYTE_W-1:0]              rx_byte,
    output logic [NSLOT-1:0]               hit
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        localparam bit ALWAYS_ON = (g == 0);
        logic enabled;
        // Slot 0 is always enabled; the other slots only in multi mode.
        always_comb enabled = ALWAYS_ON || (mode == MODE_MULTI);
        // Upper-bit equality, qualified by the slot enable.
        always_comb hit[g] = enabled && (rx_byte[BYTE_W-1:1] == slot_tbl[g][BYTE_W-1:1]);
    end
endmodule

// File: rtl/am_flags.sv
// Module: am_flags
// Arm control and sticky match flags.
// Assumes: start_det and addr_done are single-cycle pulses. START has priority over the strobe.
module am_flags #(
    parameter int NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_det,
    input  logic             addr_done,
    input  logic [NSLOT-1:0] hit,
    input  logic             rx_lsb,
    output logic             armed_q,
    output logic             match_any,
    output logic [NSLOT-1:0] match_slot,
    output logic             rx_dir
);
    logic evaluate;
    // A strobe counts only when armed and not overridden by a START.
    always_comb evaluate = addr_done && armed_q && !start_det;

    // Arm on a START; disarm once the first strobe has been used.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (start_det)
            armed_q <= 1'b1;
        else if (evaluate)
            armed_q <= 1'b0;
    end

    // Sticky flags: cleared by a START, set by an evaluated hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_slot <= '0;
            match_any  <= 1'b0;
            rx_dir     <= 1'b0;
        end else if (start_det) begin
            match_slot <= '0;
            match_any  <= 1'b0;
            rx_dir     <= 1'b0;
        end else if (evaluate && (hit != '0)) begin
            match_slot <= match_slot | hit;
            match_any  <= 1'b1;
            rx_dir     <= rx_lsb;
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
// Module: i2c_addr_matcher (top)
// Compares the first address byte after a START against up to three slots.
// Assumes: an external shifter supplies rx_byte with addr_done, and a detector supplies start_det.
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              start_det,
    input  logic              addr_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              match_any,
    output logic [NSLOT-1:0]  match_slot,
    output logic              rx_dir
);
    logic [NSLOT-1:0][BYTE_W-1:0] slot_tbl;
    am_mode_e                     mode_q;
    logic [NSLOT-1:0]             hit;
    logic                         armed_q;

    am_slot_regs #(.NSLOT(NSLOT), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .slot_tbl (slot_tbl),
        .mode     (mode_q)
    );

    am_compare #(.NSLOT(NSLOT), .BYTE_W(BYTE_W)) u_cmp (
        .slot_tbl (slot_tbl),
        .mode     (mode_q),
        .rx_byte  (rx_byte),
        .hit      (hit)
    );

    am_flags #(.NSLOT(NSLOT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .addr_done  (addr_done),
        .hit        (hit),
        .rx_lsb     (rx_byte[0]),
        .armed_q    (armed_q),
        .match_any  (match_any),
        .match_slot (match_slot),
        .rx_dir     (rx_dir)
    );
endmodule

// File: rtl/am_checker.sv
// Module: am_checker
// Temporal properties of the address matcher. It is bound into the top module.
// Assumes: the default of three slots.
module am_checker #(
    parameter int NSLOT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_det,
    input logic             addr_done,
    input logic             armed,
    input logic             mode,
    input logic             match_any,
    input logic [NSLOT-1:0] match_slot,
    input logic             rx_dir
);
    // R1: reset leaves the flags clear and the block disarmed.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (match_slot == '0 && !match_any && !rx_dir && !armed));

    // R3: in single mode an evaluated strobe never raises a flag above slot 0.
    assert_single_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && armed && !start_det && !mode) |=> (match_slot[NSLOT-1:1] == '0));

    // R6: the overall flag agrees with the per-slot flags.
    assert_any_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_any == (|match_slot)));

    // R6: the flags hold when there is neither a START nor an evaluated strobe.
    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !(addr_done && armed)) |=> ($stable(match_slot) && $stable(rx_dir)));

    // R8: a strobe while disarmed changes nothing.
    assert_disarmed_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !armed && !start_det) |=> ($stable(match_slot) && $stable(match_any)));

    // R9: a START clears the flags and arms the block.
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (match_slot == '0 && !match_any && !rx_dir && armed));
endmodule

bind i2c_addr_matcher am_checker #(.NSLOT(NSLOT)) u_am_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .addr_done  (addr_done),
    .armed      (armed_q),
    .mode       (mode_q),
    .match_any  (match_any),
    .match_slot (match_slot),
    .rx_dir     (rx_dir)
);

// File: tb/tb_i2c_addr_matcher.sv
// Bench: a behavioural reference model compared every cycle, plus directed checks.
module tb_i2c_addr_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       start_det = 1'b0;
    logic       addr_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       match_any;
    logic [2:0] match_slot;
    logic       rx_dir;

    int checks = 0;
    int fails  = 0;

    i2c_addr_matcher dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .start_det(start_det), .addr_done(addr_done), .rx_byte(rx_byte),
        .match_any(match_any), .match_slot(match_slot), .rx_dir(rx_dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model state
    int m_slot[3];
    int m_flag[3];
    int m_any, m_dir, m_armed, m_mode;

    always @(posedge clk) begin : model
        int hitv[3];
        int anyhit;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_slot[i] = 0; m_flag[i] = 0; end
            m_any = 0; m_dir = 0; m_armed = 0; m_mode = 0;
        end else begin
            anyhit = 0;
            for (int i = 0; i < 3; i++) begin
                hitv[i] = ((i == 0 || m_mode == 1) && (int'(rx_byte) / 2 == m_slot[i] / 2)) ? 1 : 0;
                anyhit = anyhit | hitv[i];
            end
            if (start_det) begin
                for (int i = 0; i < 3; i++) m_flag[i] = 0;
                m_any = 0; m_dir = 0; m_armed = 1;
            end else if (addr_done && m_armed == 1) begin
                for (int i = 0; i < 3; i++) if (hitv[i] == 1) m_flag[i] = 1;
                if (anyhit == 1) begin m_any = 1; m_dir = int'(rx_byte[0]); end
                m_armed = 0;
            end
            if (wr_en) begin
                if (wr_sel < 3) m_slot[wr_sel] = int'(wr_data);
                else m_mode = int'(wr_data[0]);
            end
        end
        #(CLK_PERIOD/4);
        chk("R6 model flags", int'(match_slot), m_flag[2]*4 + m_flag[1]*2 + m_flag[0]);
        chk("R6 model any", int'(match_any), m_any);
        chk("R5 model dir", int'(rx_dir), m_dir);
    end

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit st, input bit dn, input int b);
        @(negedge clk);
        start_det = st; addr_done = dn; rx_byte = 8'(b);
        @(negedge clk);
        start_det = 1'b0; addr_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1 reset flags", int'(match_slot), 0);
        chk("R1 reset any", int'(match_any), 0);
        rst_n = 1'b1;

        // R8: a strobe before any START is ignored (slot0 = 0x00 would match)
        pulse(0, 1, 8'h01);
        chk("R8 no start before strobe", int'(match_any), 0);

        // R3/R5: single mode, slot 0 = 0xA0, byte 0xA1 matches, dir = 1
        wr(0, 8'hA0);
        wr(1, 8'h5A);
        pulse(1, 0, 0);
        pulse(0, 1, 8'hA1);
        chk("R5 lsb ignored match", int'(match_slot), 3'b001);
        chk("R5 dir captured", int'(rx_dir), 1);

        // R8: a second strobe after evaluation is ignored
        pulse(0, 1, 8'h20);
        chk("R8 second strobe", int'(match_slot), 3'b001);
        chk("R6 sticky any", int'(match_any), 1);

        // R9: START clears
        pulse(1, 0, 0);
        chk("R9 start clears", int'(match_any), 0);

        // R3: single mode ignores slot 1
        pulse(0, 1, 8'h5A);
        chk("R3 slot1 ignored", int'(match_slot), 0);

        // R2/R4: multi mode enables slot 1
        wr(3, 1);
        pulse(1, 0, 0);
        pulse(0, 1, 8'h5B);
        chk("R2 mode write", int'(match_slot), 3'b010);
        chk("R4 multi slot1 dir", int'(rx_dir), 1);

        // R7: two slots hold the same address
        wr(2, 8'h5B);
        pulse(1, 0, 0);
        pulse(0, 1, 8'h5A);
        chk("R7 multiple flags", int'(match_slot), 3'b110);
        chk("R7 dir zero", int'(rx_dir), 0);

        // R9: START and strobe in the same cycle: the START wins and the block stays armed
        pulse(1, 1, 8'hA0);
        chk("R9 coincident start", int'(match_slot), 0);
        pulse(0, 1, 8'hA0);
        chk("R9 still armed", int'(match_slot), 3'b001);

        // R10: a slot write in the same cycle as the strobe uses the old value
        pulse(1, 0, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h10;
        addr_done = 1'b1; rx_byte = 8'hA0;
        @(negedge clk);
        wr_en = 1'b0; addr_done = 1'b0;
        chk("R10 old slot value", int'(match_slot), 3'b001);
        pulse(1, 0, 0);
        pulse(0, 1, 8'h11);
        chk("R10 new slot value", int'(match_slot), 3'b001);

        // R3: back in single mode, slot 2 cannot match
        wr(3, 0);
        pulse(1, 0, 0);
        pulse(0, 1, 8'h5A);
        chk("R3 single again", int'(match_any), 0);

        // R1: reset in mid-operation
        pulse(1, 0, 0);
        pulse(0, 1, 8'h10);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset clears", int'(match_slot), 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule